// File: doc/BRIEF.md
# Dual-Width General Purpose Register File

This block holds the thirty-two byte-wide working registers of a small 8-bit processor core. It offers two combinational read ports and one write port that is taken at the clock edge. Operand port A returns either one byte or an aligned register pair as a 16-bit word. Operand port B always returns one byte. The core write port stores either one byte or a full 16-bit pair in a single edge. An ALU operation can therefore read its operands and retire its result in the same cycle. Any read of a register that is being written in that cycle shows the value it held before the edge. Forwarding of new results is left to the pipeline around the block.

The same registers also sit at the bottom of the data address space, at addresses 0x00 to 0x1F. A load/store unit presents a data-space address. When that address falls inside the register window, the block reports a hit, returns the addressed register, and accepts a byte write into it. When a data-space write and a core write land on the same register in the same cycle, the core result is kept.

Top module: `gpr_bank`

## Requirements
- R1: After reset every register reads 0x00 on every read path.
- R2: Port B returns the byte held in register `rb_idx`. With `ra_wide` = 0, port A returns that register's byte in bits [7:0] and 0x00 in bits [15:8].
- R3: With `ra_wide` = 1, port A returns the pair based at the even index `{ra_idx[4:1],0}`. The even register appears in bits [7:0] and the odd register in bits [15:8]. Bit 0 of `ra_idx` has no effect.
- R4: With `wr_en` = 1 and `wr_wide` = 0, register `wr_idx` takes `wr_data[7:0]` at the next rising edge. Every register that no write addresses keeps its value.
- R5: With `wr_en` = 1 and `wr_wide` = 1, both bytes are stored at one edge: `wr_data[7:0]` goes to the even register `{wr_idx[4:1],0}` and `wr_data[15:8]` goes to the odd register above it. Bit 0 of `wr_idx` has no effect.
- R6: Any read in the same cycle as a write to the register being read returns the value held before the edge. The new value is visible from the following cycle.
- R7: `ds_hit` is 1 exactly when `ds_addr` is below 0x20. On a hit, `ds_rdata` is register `ds_addr[4:0]`. On a miss, `ds_rdata` is 0x00.
- R8: A data-space write (`ds_we` = 1) whose address is below 0x20 stores `ds_wdata` in register `ds_addr[4:0]` at the next edge. One at 0x20 or above changes no register.
- R9: When a core write and a data-space write address the same register in one cycle, that register takes the core byte. A data-space write to any other register in that cycle still takes effect.
- R10: With `wr_en` = 0 and `ds_we` = 0, no register changes, whatever `wr_data`, `wr_idx` and `ds_wdata` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ra_idx | input | 5 | Port A register index |
| ra_wide | input | 1 | Port A returns an aligned pair |
| ra_data | output | 16 | Port A read data |
| rb_idx | input | 5 | Port B register index |
| rb_data | output | 8 | Port B read data |
| wr_en | input | 1 | Core write enable |
| wr_wide | input | 1 | Core write stores a 16-bit pair |
| wr_idx | input | 5 | Core write register index |
| wr_data | input | 16 | Core write data, pair high byte in [15:8] |
| ds_addr | input | 8 | Data-space address from load/store logic |
| ds_we | input | 1 | Data-space byte write enable |
| ds_wdata | input | 8 | Data-space write byte |
| ds_hit | output | 1 | Address falls in the register window |
| ds_rdata | output | 8 | Data-space read byte, zero on a miss |

## Verification
The assertions take for granted that port B is never asked for a pair, which the top ties off. They also take for granted that the pair checks only apply when no data-space write targets the same register. The assertions on untouched state apply only to cycles where the data-space address misses the window or `ds_we` is low. The stimulus mixes directed phases, including same-register collisions and addresses on both sides of 0x20, with random cycles that draw the index bit 0 freely and keep every input a known value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;

    localparam int GPR_COUNT    = 32;
    localparam int GPR_BITS     = 8;
    localparam int DS_ADDR_BITS = 8;

    // Which requester updates a register in the current cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CORE = 2'd1,
        SRC_DATA = 2'd2
    } gpr_src_e;

endpackage

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
    parameter  int NUM_REGS = 32,
    parameter  int BYTE_W   = 8,
    parameter  bit WIDE_OK  = 1'b1,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int OUT_W    = WIDE_OK ? 2 * BYTE_W : BYTE_W
) (
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_i,
    input  logic [IDX_W-1:0]                idx_i,
    input  logic                            wide_i,
    output logic [OUT_W-1:0]                data_o
);

    generate
        if (WIDE_OK) begin : g_wide
            logic [IDX_W-1:0] even_idx;
            logic [IDX_W-1:0] odd_idx;
            assign even_idx = {idx_i[IDX_W-1:1], 1'b0};
            assign odd_idx  = {idx_i[IDX_W-1:1], 1'b1};
            // R3: pair read, even register low; R2: byte read zero-extended
            assign data_o = wide_i ? {regs_i[odd_idx], regs_i[even_idx]}
                                   : {{BYTE_W{1'b0}}, regs_i[idx_i]};
        end else begin : g_narrow
            assign data_o = regs_i[idx_i];
            // R2: a byte-only port is never asked for a pair
            always_comb begin
                a_r2_narrow_only: assert (!wide_i);
            end
        end
    endgenerate

endmodule

// File: rtl/gpr_ds_view.sv
module gpr_ds_view #(
    parameter  int NUM_REGS = 32,
    parameter  int BYTE_W   = 8,
    parameter  int DS_AW    = 8,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][BYTE_W-1:0] regs_i,
    input  logic [DS_AW-1:0]                addr_i,
    output logic                            hit_o,
    output logic [BYTE_W-1:0]               data_o
);

    // R7: the register window starts at address zero
    assign hit_o  = (addr_i < DS_AW'(NUM_REGS));
    assign data_o = hit_o ? regs_i[addr_i[IDX_W-1:0]] : '0;

endmodule

// File: rtl/gpr_wr_select.sv
module gpr_wr_select
    import gpr_pkg::*;
#(
    parameter  int NUM_REGS = 32,
    parameter  int BYTE_W   = 8,
    localparam int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                            core_en_i,
    input  logic                            core_wide_i,
    input  logic [IDX_W-1:0]                core_idx_i,
    input  logic [2*BYTE_W-1:0]             core_data_i,
    input  logic                            ds_en_i,
    input  logic                            ds_hit_i,
    input  logic [IDX_W-1:0]                ds_idx_i,
    input  logic [BYTE_W-1:0]               ds_data_i,
    output logic [NUM_REGS-1:0]             we_o,
    output logic [NUM_REGS-1:0][BYTE_W-1:0] wdata_o
);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic        core_sel;
            logic        ds_sel;
            logic [BYTE_W-1:0] core_byte;
            gpr_src_e    src;

            // R4/R5: narrow match on full index, pair match ignores bit 0
            assign core_sel = core_en_i &&
                (core_wide_i ? (core_idx_i[IDX_W-1:1] == (IDX_W-1)'(i >> 1))
                             : (core_idx_i == IDX_W'(i)));
            // R5: odd register of a pair takes the high byte
            assign core_byte = (core_wide_i && ((i % 2) == 1))
                             ? core_data_i[2*BYTE_W-1:BYTE_W]
                             : core_data_i[BYTE_W-1:0];
            // R8: data-space write only inside the window
            assign ds_sel = ds_en_i && ds_hit_i && (ds_idx_i == IDX_W'(i));

            // R9: core result has priority over data-space write
            always_comb begin
                if (core_sel)    src = SRC_CORE;
                else if (ds_sel) src = SRC_DATA;
                else             src = SRC_NONE;
            end

            assign we_o[i]    = (src != SRC_NONE);
            assign wdata_o[i] = (src == SRC_CORE) ? core_byte : ds_data_i;
        end
    endgenerate

endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
#(
    parameter  int NUM_REGS = GPR_COUNT,
    parameter  int BYTE_W   = GPR_BITS,
    parameter  int DS_AW    = DS_ADDR_BITS,
    localparam int IDX_W    = $clog2(NUM_REGS),
    localparam int PAIR_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic              ra_wide,
    output logic [PAIR_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [BYTE_W-1:0] rb_data,
    input  logic              wr_en,
    input  logic              wr_wide,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PAIR_W-1:0] wr_data,
    input  logic [DS_AW-1:0]  ds_addr,
    input  logic              ds_we,
    input  logic [BYTE_W-1:0] ds_wdata,
    output logic              ds_hit,
    output logic [BYTE_W-1:0] ds_rdata
);

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] reg_arr_t;

    typedef struct packed {
        reg_arr_t regs;
    } gpr_state_t;

    gpr_state_t              state_d, state_q;
    logic [NUM_REGS-1:0]     we_d;
    reg_arr_t                wbyte_d;
    logic [IDX_W-1:0]        wr_base;

    assign wr_base = {wr_idx[IDX_W-1:1], 1'b0};

    gpr_rd_port #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W), .WIDE_OK(1'b1)) u_port_a (
        .regs_i (state_q.regs),
        .idx_i  (ra_idx),
        .wide_i (ra_wide),
        .data_o (ra_data)
    );

    gpr_rd_port #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W), .WIDE_OK(1'b0)) u_port_b (
        .regs_i (state_q.regs),
        .idx_i  (rb_idx),
        .wide_i (1'b0),
        .data_o (rb_data)
    );

    gpr_ds_view #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W), .DS_AW(DS_AW)) u_ds_view (
        .regs_i (state_q.regs),
        .addr_i (ds_addr),
        .hit_o  (ds_hit),
        .data_o (ds_rdata)
    );

    gpr_wr_select #(.NUM_REGS(NUM_REGS), .BYTE_W(BYTE_W)) u_wr_select (
        .core_en_i   (wr_en),
        .core_wide_i (wr_wide),
        .core_idx_i  (wr_idx),
        .core_data_i (wr_data),
        .ds_en_i     (ds_we),
        .ds_hit_i    (ds_hit),
        .ds_idx_i    (ds_addr[IDX_W-1:0]),
        .ds_data_i   (ds_wdata),
        .we_o        (we_d),
        .wdata_o     (wbyte_d)
    );

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (we_d[i]) begin
                state_d.regs[i] = wbyte_d[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // R1: the first cycle out of reset holds an all-zero file
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (state_q == '0));

    // R4: a core byte write lands in its register
    a_r4_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide) |=> (state_q.regs[$past(wr_idx)] == $past(wr_data[BYTE_W-1:0])));

    // R5: both halves of a pair land at one edge (no data-space write in flight)
    a_r5_pair_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide && !ds_we) |=>
            ((state_q.regs[$past(wr_base)] == $past(wr_data[BYTE_W-1:0])) &&
             (state_q.regs[$past(wr_base) | IDX_W'(1)] == $past(wr_data[PAIR_W-1:BYTE_W]))));

    // R7: a miss reads back zero
    a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_hit |-> (ds_rdata == '0));

    // R8: data-space writes above the window leave the file alone
    a_r8_far_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && ds_we && !ds_hit) |=> $stable(state_q));

    // R9: a colliding data-space write loses to the core byte
    a_r9_core_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_wide && ds_we && ds_hit && (ds_addr[IDX_W-1:0] == wr_idx)) |=>
            (state_q.regs[$past(wr_idx)] == $past(wr_data[BYTE_W-1:0])));

    // R10: no enable, no change
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !ds_we) |=> $stable(state_q));

endmodule

// File: tb/gpr_bank_tb.sv
module gpr_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ra_idx = '0;
    logic        ra_wide = 1'b0;
    logic [15:0] ra_data;
    logic [4:0]  rb_idx = '0;
    logic [7:0]  rb_data;
    logic        wr_en = 1'b0;
    logic        wr_wide = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  ds_addr = '0;
    logic        ds_we = 1'b0;
    logic [7:0]  ds_wdata = '0;
    logic        ds_hit;
    logic [7:0]  ds_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int model [32];

    always #10 clk = ~clk;

    gpr_bank u_dut (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(ra_idx), .ra_wide(ra_wide), .ra_data(ra_data),
        .rb_idx(rb_idx), .rb_data(rb_data),
        .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
        .ds_addr(ds_addr), .ds_we(ds_we), .ds_wdata(ds_wdata),
        .ds_hit(ds_hit), .ds_rdata(ds_rdata)
    );

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare all read paths against the model, then let one edge pass
    task automatic cycle(string req);
        int ea;
        int base;
        #1;
        base = int'(ra_idx) & 30;
        if (ra_wide) ea = (model[base + 1] << 8) | model[base];
        else         ea = model[ra_idx];
        check(req, "ra_data", int'(ra_data), ea);
        check(req, "rb_data", int'(rb_data), model[rb_idx]);
        check(req, "ds_hit", int'(ds_hit), (ds_addr < 8'h20) ? 1 : 0);
        check(req, "ds_rdata", int'(ds_rdata), (ds_addr < 8'h20) ? model[ds_addr] : 0);
        @(posedge clk);
        if (ds_we && ds_addr < 8'h20) model[ds_addr] = int'(ds_wdata);
        if (wr_en) begin
            if (wr_wide) begin
                model[int'(wr_idx) & 30]       = int'(wr_data[7:0]);
                model[(int'(wr_idx) & 30) + 1] = int'(wr_data[15:8]);
            end else begin
                model[wr_idx] = int'(wr_data[7:0]);
            end
        end
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 1'b0; ds_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        foreach (model[i]) model[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: sweep every register on every path right after reset
        for (int i = 0; i < 32; i++) begin
            ra_idx = 5'(i); rb_idx = 5'(31 - i); ds_addr = 8'(i); ra_wide = i[0];
            wr_data = 16'hFFFF; ds_wdata = 8'hFF;
            cycle("R1");
        end

        // R4: narrow writes to every register, reads follow one behind (R6)
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'(i); wr_data = 16'(16'hAB00 | (i * 7 + 3));
            ra_wide = 1'b0; ra_idx = 5'(i); rb_idx = 5'(i); ds_addr = 8'(i);
            cycle("R6");
        end
        quiet();
        for (int i = 0; i < 32; i++) begin
            rb_idx = 5'(i); ra_idx = 5'(i); ra_wide = 1'b0; ds_addr = 8'(i);
            cycle("R4");
        end

        // R5: pair writes using odd indices, then pair reads both alignments (R3)
        for (int i = 0; i < 16; i++) begin
            wr_en = 1'b1; wr_wide = 1'b1; wr_idx = 5'(2 * i + 1);
            wr_data = 16'((i * 16'h1357) ^ 16'h5AA5);
            ra_wide = 1'b1; ra_idx = 5'(2 * i); rb_idx = 5'(2 * i + 1);
            cycle("R5");
        end
        quiet();
        for (int i = 0; i < 32; i++) begin
            ra_wide = 1'b1; ra_idx = 5'(i); rb_idx = 5'(i);
            cycle("R3");
        end

        // R10: enables low with busy data
        for (int i = 0; i < 8; i++) begin
            quiet(); wr_idx = 5'(i); wr_data = 16'hDEAD; ds_addr = 8'(i); ds_wdata = 8'hBE;
            ra_idx = 5'(i); rb_idx = 5'(i);
            cycle("R10");
        end

        // R7/R8: data-space writes inside and beyond the window
        for (int i = 0; i < 64; i++) begin
            quiet(); ds_we = 1'b1; ds_addr = 8'(i * 4 + (i % 3)); ds_wdata = 8'(i * 11 + 1);
            rb_idx = ds_addr[4:0]; ra_idx = ds_addr[4:0]; ra_wide = 1'b0;
            cycle("R8");
        end
        quiet();
        for (int i = 0; i < 40; i++) begin
            ds_addr = 8'(i); rb_idx = 5'(i);
            cycle("R7");
        end
        ds_addr = 8'h1F; cycle("R7");
        ds_addr = 8'h20; cycle("R7");
        ds_addr = 8'hFF; cycle("R7");

        // R9: collisions, same register and pair overlap, plus a disjoint pair
        for (int i = 0; i < 32; i++) begin
            wr_en = 1'b1; wr_wide = i[0]; wr_idx = 5'(i); wr_data = 16'(16'h1100 + i);
            ds_we = 1'b1; ds_addr = 8'(i ^ (i % 4 == 3 ? 1 : 0)); ds_wdata = 8'hC3;
            ra_idx = 5'(i); rb_idx = 5'(i);
            cycle("R9");
            quiet();
            ds_addr = 8'(i); ra_wide = 1'b0;
            cycle("R9");
        end
        wr_en = 1'b1; wr_wide = 1'b0; wr_idx = 5'd4; wr_data = 16'h0077;
        ds_we = 1'b1; ds_addr = 8'd9; ds_wdata = 8'h99;
        cycle("R9");
        quiet(); ds_addr = 8'd9; rb_idx = 5'd4;
        cycle("R9");

        // R2: mixed random traffic on every path
        for (int n = 0; n < 3000; n++) begin
            wr_en = 1'($urandom); wr_wide = 1'($urandom); wr_idx = 5'($urandom);
            wr_data = 16'($urandom); ds_we = 1'($urandom);
            ds_addr = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 32);
            ds_wdata = 8'($urandom); ra_idx = 5'($urandom); ra_wide = 1'($urandom);
            rb_idx = 5'($urandom);
            cycle("R2");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule